// File: doc/BRIEF.md
# I2C Bus Recovery Sequencer

This block returns a two-wire bus to idle after a target device was left partway through a byte, for example after the controller was reset while the device kept its state. When a run begins, SDA is left released and SCL is pulsed low and high a fixed number of times. Any device still shifting data out then finishes its byte and lets go of SDA. The block then forms a STOP condition and leaves both lines released.

Both lines are open-drain. The block drives two enables, and an enable at 1 pulls its line low. A high level comes only from releasing the line. Timing is set in units. One unit is a count of system clock cycles, taken from an input when a run is accepted. A run can be requested with a start pulse. With the default parameter setting, a run also begins by itself on the first clock after reset, so the bus is clean before the controller accepts any transaction. `busy` covers the run. `done` marks its end for a single cycle.

Top module: `i2c_bus_recover`

## Requirements
- R1: While reset is asserted, `busy`, `done`, `scl_pull` and `sda_pull` are all 0.
- R2: A run produces exactly PULSES (default 9) separate intervals of `scl_pull` = 1 with `sda_pull` = 0, before the STOP begins.
- R3: In the clock-out part of a run, every SCL low interval (`scl_pull` = 1) and every SCL high interval (`scl_pull` = 0) lasts 2*U system cycles. U is `unit_cycles` sampled when the run is accepted, and a value of 0 is taken as 1.
- R4: After the last high interval, the STOP runs as four steps of U cycles each, in this order: SCL pulled only; SCL and SDA pulled; SDA pulled only; both released. `sda_pull` therefore rises exactly once per run, while SCL is pulled, and falls while SCL is released.
- R5: Outside a run, both pull enables are 0. The block has no output that can drive a line high.
- R6: `busy` is 1 for exactly (4*PULSES + 4)*U cycles per run, starting on the cycle after acceptance. `done` is 1 for exactly one cycle: the first cycle in which `busy` is 0 again.
- R7: `start` has no effect while `busy` is 1. A request made in the `done` cycle or later, while idle, is accepted.
- R8: When RUN_AT_RESET is 1, a run is accepted on the first clock edge after reset is released, with no `start` request.
- R9: Changes to `unit_cycles` while `busy` is 1 do not alter the timing of the current run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a recovery run; used only while idle |
| unit_cycles | input | UNIT_W | System cycles per timing unit; 0 is treated as 1 |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse when a run has finished |
| scl_pull | output | 1 | 1 pulls SCL low; 0 releases it |
| sda_pull | output | 1 | 1 pulls SDA low; 0 releases it |

## Verification
The assertions assume that reset is released synchronously with respect to sampling, and that `start` and `unit_cycles` change only between clock edges. They do not assume that `start` stays low during a run: a correct design must ignore it there. The bench changes inputs on the falling clock edge only. It raises `start` repeatedly during runs and holds it high across a `done` cycle. It changes `unit_cycles` mid-run and also applies 0, so that the latching and minimum-unit rules are exercised within these assumptions.

// File: rtl/i2c_bus_recover.sv
module i2c_bus_recover #(
  parameter int UNIT_W       = 12,
  parameter int PULSES       = 9,
  parameter bit RUN_AT_RESET = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [UNIT_W-1:0] unit_cycles,
  output logic              busy,
  output logic              done,
  output logic              scl_pull,
  output logic              sda_pull
);

  localparam int CW = UNIT_W + 1;
  localparam int PW = (PULSES > 1) ? $clog2(PULSES) : 1;

  typedef enum logic [2:0] {
    IDLE, CLK_LO, CLK_HI, STP_SCL, STP_BOTH, STP_SDA, STP_REL
  } phase_t;

  phase_t            phase;
  logic [UNIT_W-1:0] unit_q;
  logic [CW-1:0]     cnt;
  logic [CW-1:0]     span;
  logic [PW-1:0]     pulse_n;
  logic              pend_init;
  logic              last_tick;
  logic              go;

  assign busy      = (phase != IDLE);
  assign scl_pull  = (phase == CLK_LO) || (phase == STP_SCL) || (phase == STP_BOTH);
  assign sda_pull  = (phase == STP_BOTH) || (phase == STP_SDA);
  assign span      = (phase == CLK_LO || phase == CLK_HI) ? {unit_q, 1'b0} : {1'b0, unit_q};
  assign last_tick = (cnt == span - 1'b1);
  assign go        = start || pend_init;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= IDLE;
      unit_q    <= '0;
      cnt       <= '0;
      pulse_n   <= '0;
      pend_init <= RUN_AT_RESET;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      if (phase == IDLE) begin
        if (go) begin
          phase     <= CLK_LO;
          unit_q    <= (unit_cycles == '0) ? UNIT_W'(1) : unit_cycles;
          cnt       <= '0;
          pulse_n   <= '0;
          pend_init <= 1'b0;
        end
      end else if (last_tick) begin
        cnt <= '0;
        unique case (phase)
          CLK_LO:   phase <= CLK_HI;
          CLK_HI:
            if (pulse_n == PW'(PULSES - 1)) phase <= STP_SCL;
            else begin
              pulse_n <= pulse_n + 1'b1;
              phase   <= CLK_LO;
            end
          STP_SCL:  phase <= STP_BOTH;
          STP_BOTH: phase <= STP_SDA;
          STP_SDA:  phase <= STP_REL;
          STP_REL: begin
            phase <= IDLE;
            done  <= 1'b1;
          end
          default:  phase <= IDLE;
        endcase
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R4
  sda_set_under_low_scl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> scl_pull);

  // R4
  sda_free_under_high_scl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_pull) |-> !scl_pull);

  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6
  done_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R5
  idle_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!scl_pull && !sda_pull));

  // R9
  unit_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(unit_q));

  // R7
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !(phase == STP_REL && last_tick)) |=> busy);

endmodule

// File: tb/sim_i2c_bus_recover.sv
module sim_i2c_bus_recover;
  localparam int UW = 12;
  localparam int NP = 9;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [UW-1:0] unit_cycles = '0;
  logic          busy, done, scl_pull, sda_pull;

  i2c_bus_recover #(.UNIT_W(UW), .PULSES(NP), .RUN_AT_RESET(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .unit_cycles(unit_cycles),
    .busy(busy), .done(done), .scl_pull(scl_pull), .sda_pull(sda_pull));

  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // reference model: queue of expected {busy,scl,sda,done} per cycle
  logic [3:0] mq[$];
  string      tq[$];
  logic [3:0] cur = 4'b0000;
  string      cur_tag = "R1";
  bit         pend = 1'b1;
  int         last_u = 1;

  task automatic push_n(input logic [3:0] v, input int n, input string t);
    for (int i = 0; i < n; i++) begin
      mq.push_back(v);
      tq.push_back(t);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      mq.delete(); tq.delete();
      cur = 4'b0000; cur_tag = "R1"; pend = 1'b1;
    end else begin
      if (mq.size() == 0 && !cur[3] && (start || pend)) begin
        int u;
        u = (unit_cycles == 0) ? 1 : int'(unit_cycles);
        last_u = u;
        pend = 1'b0;
        for (int p = 0; p < NP; p++) begin
          push_n(4'b1100, 2*u, "R3");
          push_n(4'b1000, 2*u, "R3");
        end
        push_n(4'b1100, u, "R4");
        push_n(4'b1110, u, "R4");
        push_n(4'b1010, u, "R4");
        push_n(4'b1000, u, "R4");
        push_n(4'b0001, 1, "R6");
      end
      if (mq.size() > 0) begin
        cur = mq.pop_front(); cur_tag = tq.pop_front();
      end else begin
        cur = 4'b0000; cur_tag = "R7";
      end
    end
  end

  // per-run tallies
  int  scl_rises = 0, sda_rises = 0, busy_len = 0, cyc = 0;
  logic p_scl = 1'b0, p_sda = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      chk(cur_tag, {busy, scl_pull, sda_pull, done}, cur);
      if (scl_pull && !p_scl && !sda_pull) scl_rises++;
      if (sda_pull && !p_sda) sda_rises++;
      if (busy) busy_len++;
      if (done) begin
        chk("R2", scl_rises, NP + 1);
        chk("R4", sda_rises, 1);
        chk("R6", busy_len, (4*NP + 4) * last_u);
        chk("R5", {scl_pull, sda_pull}, 0);
        scl_rises = 0; sda_rises = 0; busy_len = 0;
      end
    end
    p_scl = scl_pull; p_sda = sda_pull;
    if (cyc > 20000) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic wait_done();
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    unit_cycles = 12'd3;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", {busy, done, scl_pull, sda_pull}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R8 automatic run after reset
    chk("R8", busy, 1);
    wait_done();
    repeat (5) @(negedge clk);
    chk("R7", busy, 0);

    // R9: unit changes mid-run; R7: start pulses mid-run
    unit_cycles = 12'd1;
    start = 1'b1; @(negedge clk); start = 1'b0;
    repeat (7) @(negedge clk);
    unit_cycles = 12'd6;
    start = 1'b1; @(negedge clk); start = 1'b0;
    repeat (10) @(negedge clk);
    start = 1'b1; @(negedge clk); start = 1'b0;
    wait_done();
    chk("R9", last_u, 1);

    // R3: zero unit treated as one
    unit_cycles = 12'd0;
    start = 1'b1; @(negedge clk); start = 1'b0;
    wait_done();

    // R7: start held high across done -> back-to-back runs
    unit_cycles = 12'd2;
    start = 1'b1;
    wait_done();
    unit_cycles = 12'd4;
    while (!busy) @(negedge clk);
    start = 1'b0;
    wait_done();
    repeat (4) @(negedge clk);
    chk("R5", {busy, scl_pull, sda_pull}, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule